// File: doc/BRIEF.md
# Serial-Configured Clock Output Gate Controller

This block lets a host switch each of six copies of a reference clock on or off over a two-wire serial bus. It is a write-only slave. Every write is a fixed ten-byte frame: the address byte, two bytes the block ignores (a command code and a byte count), then seven data bytes. Only three of the data bytes carry enable bits, and those bits are scattered across the bytes. All other bits and bytes are acknowledged and then dropped.

The bus pins are sampled by a system clock that runs much faster than the bus. The data pin is open-drain: the block only ever pulls it low, and only to acknowledge a byte. Each output is the reference clock ANDed with its own enable. An enable that changes is passed into the reference clock domain and takes effect only while that clock is low, so a gated output never shows a shortened pulse.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: After reset all six enables are 1, every clk_o bit follows ref_clk_i, and sda_oe_o is 0.
- R2: The only address byte acknowledged is 8'hD2. After any other address the block acknowledges nothing more in that frame and no enable changes.
- R3: The second and third bytes of a frame are acknowledged, and their contents have no effect.
- R4: Every byte is taken most significant bit first, one bit per rising SCL edge.
- R5: Data byte 0 (frame byte 3) sets three enables: bit 0 sets output 0, bit 2 sets output 1, and bit 7 sets output 2.
- R6: Data byte 1 (frame byte 4) sets two enables: bit 3 sets output 4 and bit 6 sets output 5. Data byte 2 (frame byte 5) sets one: bit 7 sets output 3.
- R7: When an output's enable is 1 it follows ref_clk_i. When its enable is 0 it is held at 0.
- R8: Data bytes 3 to 6 (frame bytes 6 to 9) are acknowledged but not stored. The bits that R5 and R6 do not name have no effect.
- R9: After each accepted byte, the block raises sda_oe_o on the following SCL fall, holds it through the ninth SCL high phase, and drops it on the next SCL fall.
- R10: A STOP (SDA rising while SCL is high) ends the frame. A START (SDA falling while SCL is high) restarts frame reception at the address byte at any point, even in the middle of a frame.
- R11: An output rises only while ref_clk_i is high and falls only while ref_clk_i is low, so no shortened pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock |
| sda_i | input | 1 | Serial bus data, as seen on the wire |
| sda_oe_o | output | 1 | When 1, pull the data line low (acknowledge) |
| ref_clk_i | input | 1 | Reference clock to fan out |
| clk_o | output | 6 | Gated copies of ref_clk_i |

## Verification
The assertions assume three things about the bus. The system clock samples SCL at least several times in each SCL phase. SDA changes only while SCL is low, except at START and STOP. ref_clk_i has no edge that coincides with a system clock edge. The bench drives SCL with each phase lasting eight or more system cycles and moves SDA well inside the low phase. It runs the reference clock at an even-nanosecond period, while the system clock edges fall on odd nanoseconds.

// File: rtl/smb_fanout_pkg.sv
package smb_fanout_pkg;
  localparam int unsigned NUM_OUT     = 6;
  localparam int unsigned FRAME_BYTES = 10;
  localparam int unsigned DATA_BASE   = 3;
  localparam logic [7:0]  SLV_ADDR    = 8'hD2;
  localparam int unsigned IDX_W       = $clog2(FRAME_BYTES + 1);

  // data byte and bit that control each output
  localparam int unsigned EN_BYTE [NUM_OUT] = '{0, 0, 0, 2, 1, 1};
  localparam int unsigned EN_BIT  [NUM_OUT] = '{0, 2, 7, 7, 3, 6};

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_ACK, S_IGN} rx_state_e;
endpackage

// File: rtl/smb_sync_edge.sv
module smb_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign q_o    = sync_q[STAGES-1];
  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/smb_write_rx.sv
module smb_write_rx
  import smb_fanout_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             wr_stb_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;

  smb_sync_edge #(.STAGES(2)) u_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i),
    .q_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall));
  smb_sync_edge #(.STAGES(2)) u_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i),
    .q_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall));

  logic start_det, stop_det;
  assign start_det = sda_fall & scl_s;
  assign stop_det  = sda_rise & scl_s;

  rx_state_e        state_q;
  logic [3:0]       bit_cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       shreg_q;
  logic             ack_hi_q;
  logic             oe_q;

  logic byte_done, reject, accept;
  assign byte_done = (state_q == S_BITS) && scl_fall && (bit_cnt_q == 4'd8)
                     && !start_det && !stop_det;
  assign reject    = ((idx_q == '0) && (shreg_q != SLV_ADDR))
                     || (idx_q >= IDX_W'(FRAME_BYTES));
  assign accept    = byte_done && !reject;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      ack_hi_q  <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_det) begin
      state_q   <= S_BITS;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      ack_hi_q  <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      state_q   <= S_IDLE;
      oe_q      <= 1'b0;
    end else begin
      unique case (state_q)
        S_BITS: begin
          if (scl_rise && (bit_cnt_q < 4'd8)) begin
            shreg_q   <= {shreg_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            if (reject) begin
              state_q <= S_IGN;
            end else begin
              state_q  <= S_ACK;
              oe_q     <= 1'b1;
              ack_hi_q <= 1'b0;
            end
          end
        end
        S_ACK: begin
          if (scl_rise) begin
            ack_hi_q <= 1'b1;
          end else if (scl_fall && ack_hi_q) begin
            oe_q      <= 1'b0;
            state_q   <= S_BITS;
            bit_cnt_q <= '0;
            idx_q     <= idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_stb_o  = accept;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = shreg_q;

  assert_ack_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));
  assert_ack_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));
  assert_bad_addr_nack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && (idx_q == '0) && (shreg_q != SLV_ADDR)) |=> !sda_oe_o);
  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == S_BITS && idx_q == '0 && !sda_oe_o));
endmodule

// File: rtl/fanout_en_map.sv
module fanout_en_map
  import smb_fanout_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_stb_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_data_i,
  output logic [NUM_OUT-1:0] en_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_en
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(DATA_BASE + EN_BYTE[g]);
    localparam int unsigned      MY_BIT = EN_BIT[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             en_o[g] <= 1'b1;
      else if (wr_stb_i && wr_idx_i == MY_IDX) en_o[g] <= wr_data_i[MY_BIT];
    end
  end

  // frame bytes outside data bytes 0..2 never touch the enables
  assert_unmapped_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && (wr_idx_i < IDX_W'(DATA_BASE) || wr_idx_i > IDX_W'(DATA_BASE + 2)))
    |=> $stable(en_o));
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic [SYNC_STAGES-1:0] en_sync_q;

  // retimed on the falling edge: enable only moves while ref clock is low
  always_ff @(negedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_sync_q <= '1;
    else         en_sync_q <= {en_sync_q[SYNC_STAGES-2:0], en_i};
  end

  assign gclk_o = ref_clk_i & en_sync_q[SYNC_STAGES-1];

  assert_rise_in_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gclk_o) |-> ref_clk_i);
  assert_fall_in_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gclk_o) |-> !ref_clk_i);
endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
  import smb_fanout_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               ref_clk_i,
  output logic [NUM_OUT-1:0] clk_o
);
  logic               wr_stb;
  logic [IDX_W-1:0]   wr_idx;
  logic [7:0]         wr_data;
  logic [NUM_OUT-1:0] en;

  smb_write_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data));

  fanout_en_map u_map (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_i(wr_stb), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .en_o(en));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    clk_out_gate #(.SYNC_STAGES(2)) u_gate (
      .clk_i(clk_i), .rst_ni(rst_ni), .ref_clk_i(ref_clk_i),
      .en_i(en[g]), .gclk_o(clk_o[g]));
  end
endmodule

// File: tb/clk_fanout_ctrl_test.sv
`timescale 1ns/1ps
module clk_fanout_ctrl_test;
  localparam real CLK_PERIOD = 10.0;
  localparam real REF_HALF   = 22.0;
  localparam int  Q          = 8;

  logic       clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, sda_line;
  logic [5:0] clk_out;
  int checks = 0, failures = 0;
  bit done = 0;

  assign sda_line = sda_m & ~sda_oe;

  clk_fanout_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .ref_clk_i(ref_clk), .clk_o(clk_out));

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin
    #2;
    forever #(REF_HALF) ref_clk = ~ref_clk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] map_en(input logic [7:0] d0, d1, d2);
    return {d1[6], d1[3], d2[7], d0[7], d0[2], d0[0]};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic smb_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic smb_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(2*Q);
  endtask

  // R4: shifted MSB first
  task automatic send_byte(input logic [7:0] b, output bit acked, output bit held);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q);
      scl_m = 1'b1; wt(2*Q);
      scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    acked = !sda_line;
    held  = sda_oe;
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic write_frame(input logic [7:0] addr, input logic [7:0] d[7],
                             input logic [7:0] cmd, input logic [7:0] cnt,
                             output int acks);
    bit a, h;
    logic [7:0] fb[10];
    fb[0] = addr; fb[1] = cmd; fb[2] = cnt;
    for (int k = 0; k < 7; k++) fb[3+k] = d[k];
    acks = 0;
    smb_start();
    for (int k = 0; k < 10; k++) begin
      send_byte(fb[k], a, h);
      if (a) acks++;
      if (a && k == 0) chk(h, "R9 ack held in ninth high", h, 1);
      chk(!sda_oe, "R9 ack released after ninth clock", sda_oe, 0);
    end
    smb_stop();
  endtask

  task automatic check_out(input logic [5:0] exp, input string tag);
    repeat (3) @(negedge ref_clk);
    @(posedge ref_clk); #3;
    chk(clk_out == exp, {tag, " high phase"}, clk_out, exp);
    @(negedge ref_clk); #3;
    chk(clk_out == 6'h00, {tag, " low phase"}, clk_out, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [5:0] exp_en;
    logic [7:0] d[7];
    int acks;
    bit a, h;
    void'($urandom(32'h5eed_1234));
    wt(5);
    rst_n = 1'b1;
    wt(5);
    exp_en = 6'h3F;
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda_oe idle", sda_oe, 0);
    check_out(6'h3F, "R1 reset enables");

    // R5 R4: byte0 bit0 only, MSB-first order matters
    d = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    write_frame(8'hD2, d, 8'h00, 8'h07, acks);
    chk(acks == 10, "R2 R3 all bytes acked", acks, 10);
    exp_en = map_en(d[0], d[1], d[2]);
    check_out(exp_en, "R4 R5 byte0 bit0 only");

    // R6 R7: byte1/byte2 bits
    d = '{8'h00, 8'h48, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00};
    write_frame(8'hD2, d, 8'hA5, 8'h5A, acks);
    exp_en = map_en(d[0], d[1], d[2]);
    check_out(exp_en, "R6 R7 byte1 byte2 enables");

    // R8: reserved bits set and trailing bytes all ones have no effect
    d = '{8'h7A, 8'hB7, 8'h7F, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    write_frame(8'hD2, d, 8'hFF, 8'hFF, acks);
    chk(acks == 10, "R8 trailing bytes acked", acks, 10);
    exp_en = map_en(d[0], d[1], d[2]);
    chk(exp_en == 6'h00, "R8 model sanity", exp_en, 0);
    check_out(exp_en, "R8 reserved and trailing ignored");

    // R2: wrong address, no ack, no change
    d = '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00};
    write_frame(8'hD3, d, 8'h00, 8'h00, acks);
    chk(acks == 0, "R2 wrong address nacked", acks, 0);
    check_out(exp_en, "R2 wrong address no change");

    // R10: repeated START mid-frame restarts at address
    smb_start();
    send_byte(8'hD2, a, h);
    send_byte(8'h11, a, h);
    smb_start();
    send_byte(8'hD2, a, h);
    chk(a, "R10 restart address acked", a, 1);
    send_byte(8'h00, a, h);
    send_byte(8'h00, a, h);
    send_byte(8'h85, a, h);
    chk(a, "R10 data after restart acked", a, 1);
    smb_stop();
    exp_en = {exp_en[5:3], 1'b1, 1'b1, 1'b1};
    check_out(exp_en, "R10 restart frame applied");

    // R10: STOP mid-frame, then a bare data byte is not taken
    smb_start();
    send_byte(8'hD2, a, h);
    smb_stop();
    send_byte(8'hFF, a, h);
    chk(!a, "R10 no ack after stop", a, 0);
    smb_stop();
    check_out(exp_en, "R10 stop leaves enables");

    // random frames
    for (int t = 0; t < 16; t++) begin
      logic [7:0] addr;
      addr = ($urandom % 4 == 0) ? 8'($urandom) : 8'hD2;
      for (int k = 0; k < 7; k++) d[k] = 8'($urandom);
      write_frame(addr, d, 8'($urandom), 8'($urandom), acks);
      if (addr == 8'hD2) begin
        exp_en = map_en(d[0], d[1], d[2]);
        chk(acks == 10, "R3 random frame acks", acks, 10);
      end else begin
        chk(acks == 0, "R2 random bad address acks", acks, 0);
      end
      check_out(exp_en, "R7 random frame outputs");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule